// File: doc/BRIEF.md
# MDIO Management Engine

This block turns one host write to a command register into a single clause 22 management frame on the MDC/MDIO pins. The host first loads the data for a write into a 16-bit write-data register. It then writes a command word that carries the operation request, the PHY address and the PHY register number.

While the frame runs, the requested operation bit reads back as 1, so it also serves as the busy flag. The host polls that bit. When it has cleared, the 16 bits returned by the PHY for a read are waiting in a separate read-data register.

MDC is derived from the system clock by a divider whose half period is the parameter `MDC_HALF`, given in system clocks. The engine drives MDIO during the low phase of MDC and samples it on the rising edge. During the turnaround and the data field of a read, the engine releases the line by pulling its output enable low.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, `cmd_o` and `rdata_o` are 0, `mdc_o` is low, `mdio_oe_o` is low and `mdio_o` is 1.
- R2: A command write (`reg_addr_i`=0) while idle stores the whole 16-bit word, which is visible on `cmd_o` from the next cycle. The command fields are:
  - bit 14: write request
  - bit 13: read request
  - bits [12:8]: PHY address
  - bits [4:0]: PHY register number
- R3: The requested operation bit stays 1 during the transaction and clears by itself exactly 128*MDC_HALF system cycles after the command write edge. All other command bits are kept.
- R4: Each frame is sent MSB first, in this order:
  - 32 ones
  - start code 01
  - opcode: 10 for a read, 01 for a write
  - 5 PHY address bits
  - 5 register bits
  - for a write: turnaround 10, then the 16 data bits
- R5: MDC has a half period of MDC_HALF system cycles, is low whenever idle, and makes exactly 64 rising edges per transaction. MDIO changes only while MDC is low.
- R6: During a read, `mdio_oe_o` is low for bit positions 46 to 63. The 16 bits sampled on the rising MDC edges of positions 48 to 63 (first sample is the MSB) appear on `rdata_o` once the read bit has cleared.
- R7: A write transaction leaves `rdata_o` unchanged.
- R8: A command write issued while a transaction is in progress is ignored. `cmd_o` and the frame on the wire are unaffected.
- R9: A command word with neither bit 14 nor bit 13 set is stored, but starts no frame, and MDC stays low.
- R10: With both bit 14 and bit 13 set, a write frame is sent, and both bits clear at completion.
- R11: The write-data register (`reg_addr_i`=1) may be loaded at any time. A frame uses the value held at the command write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 1 | Write target: 0 = command, 1 = write data |
| reg_wdata_i | input | 16 | Host write value |
| cmd_o | output | 16 | Command register readback; bits 14 and 13 serve as busy flags |
| rdata_o | output | 16 | Read-data register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO input value |

## Verification
A divider or bit counter that is off by one shows up straight away in two places: the number of MDC rising edges in a frame, and the exact cycle in which the busy bit clears. Either moves by at least MDC_HALF cycles within the first transaction.

A sequencer that drops out of step with the command register leaves the busy bit stuck or cleared early. A wrong shift order or a wrong field placement corrupts the bits captured on the wire within the first 46 MDC periods. A mistimed turnaround release or a misplaced read sample changes `rdata_o` at the end of the first read.

A command accepted while busy changes `cmd_o` on the very next cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned PRE_BITS   = 32;
  localparam int unsigned TA_POS     = 46;
  localparam int unsigned DATA_POS   = 48;
  localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
  localparam int unsigned CMD_WR     = 14;
  localparam int unsigned CMD_RD     = 13;
  localparam logic ADDR_CMD   = 1'b0;
  localparam logic ADDR_WDATA = 1'b1;

  typedef logic [FRAME_BITS-1:0] frame_t;

  function automatic frame_t build_frame(input logic is_wr, input logic [4:0] phy,
                                         input logic [4:0] regn, input logic [15:0] wd);
    logic [1:0] opc;
    logic [1:0] ta;
    opc = is_wr ? 2'b01 : 2'b10;
    ta  = is_wr ? 2'b10 : 2'b11;
    return {{PRE_BITS{1'b1}}, 2'b01, opc, phy, regn, ta, wd};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick = run_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (start_i || !run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;

  // R5
  mdc_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |=> (mdc_o != $past(mdc_o)));
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        is_wr_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  reg_i,
  input  logic [15:0] wdata_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        active_o,
  output logic        done_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic [15:0] rdata_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic             active_q;
  logic             wr_q;
  logic [IDX_W-1:0] idx_q;
  frame_t           sr_q;
  logic [15:0]      rd_sr_q;

  assign done_o = active_q && fall_i && (idx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      idx_q    <= '0;
      sr_q     <= '1;
      rd_sr_q  <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      wr_q     <= is_wr_i;
      idx_q    <= '0;
      sr_q     <= build_frame(is_wr_i, phy_i, reg_i, wdata_i);
    end else if (active_q) begin
      if (rise_i && !wr_q && (idx_q >= IDX_W'(DATA_POS)))
        rd_sr_q <= {rd_sr_q[14:0], mdio_i};
      if (fall_i) begin
        if (idx_q == LAST) begin
          active_q <= 1'b0;
          sr_q     <= '1;
        end else begin
          idx_q <= idx_q + 1'b1;
          sr_q  <= {sr_q[FRAME_BITS-2:0], 1'b1};
        end
      end
    end
  end

  assign active_o  = active_q;
  assign mdio_o    = active_q ? sr_q[FRAME_BITS-1] : 1'b1;
  assign mdio_oe_o = active_q && (wr_q || (idx_q < IDX_W'(TA_POS)));
  assign rdata_o   = rd_sr_q;

  // R4
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !active_o);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int unsigned MDC_HALF = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] cmd_o,
  output logic [15:0] rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int unsigned FRAME_CYC = 2 * FRAME_BITS * MDC_HALF;
  localparam int unsigned BCW       = $clog2(FRAME_CYC + 1) + 1;

  logic [15:0] cmd_q, wdata_q, rdata_q;
  logic        busy, cmd_we, start, op_req, done, seq_active, rise, fall;
  logic [15:0] seq_rdata;

  assign busy   = cmd_q[CMD_WR] | cmd_q[CMD_RD];
  assign cmd_we = reg_we_i && (reg_addr_i == ADDR_CMD);
  assign op_req = reg_wdata_i[CMD_WR] | reg_wdata_i[CMD_RD];
  assign start  = cmd_we && !busy && op_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we_i && (reg_addr_i == ADDR_WDATA))
        wdata_q <= reg_wdata_i;
      if (cmd_we && !busy) begin
        cmd_q <= reg_wdata_i;
      end else if (done) begin
        cmd_q[CMD_WR] <= 1'b0;
        cmd_q[CMD_RD] <= 1'b0;
        if (!cmd_q[CMD_WR]) rdata_q <= seq_rdata;
      end
    end
  end

  mdio_clkgen #(.HALF(MDC_HALF)) u_clkgen (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .run_i   (seq_active),
    .mdc_o   (mdc_o),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  mdio_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .is_wr_i   (reg_wdata_i[CMD_WR]),
    .phy_i     (reg_wdata_i[12:8]),
    .reg_i     (reg_wdata_i[4:0]),
    .wdata_i   (wdata_q),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (seq_active),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rdata_o   (seq_rdata)
  );

  assign cmd_o   = cmd_q;
  assign rdata_o = rdata_q;

  logic [BCW-1:0] busy_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   busy_cnt_q <= '0;
    else if (busy) busy_cnt_q <= busy_cnt_q + 1'b1;
    else           busy_cnt_q <= '0;
  end

  // R3
  busy_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy == seq_active);
  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (busy_cnt_q < BCW'(FRAME_CYC)));
  // R5
  mdc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  // R5
  mdio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> $stable(mdio_o));
  // R8
  cmd_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && busy && !done) |=> (cmd_o == $past(cmd_o)));
  // R9
  noop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we && !busy && !op_req) |=> !busy);
endmodule

// File: tb/mdio_cmd_engine_tb.sv
`timescale 1ns/1ps
module mdio_cmd_engine_tb;
  localparam int HALF = 4;
  localparam int FRAME_CYC = 128 * HALF;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_addr_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] cmd_o, rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o;
  logic        mdio_i = 1'b1;

  mdio_cmd_engine #(.MDC_HALF(HALF)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .cmd_o(cmd_o), .rdata_o(rdata_o), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
  );

  always #2 clk_i = ~clk_i;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // PHY model
  int          rise_n = 0;
  logic [63:0] cap = '0;
  logic [15:0] resp = '0;
  bit          rd_mode = 0;
  bit          oe_bad = 0;

  always @(posedge mdc_o) begin
    if (rd_mode && rise_n >= 46 && mdio_oe_o) oe_bad = 1;
    cap = {cap[62:0], mdio_o};
    rise_n++;
  end

  always @(negedge mdc_o) begin
    if (rd_mode && rise_n >= 48 && rise_n <= 63) mdio_i = resp[63 - rise_n];
    else if (rd_mode && rise_n == 47)            mdio_i = 1'b0;
    else                                          mdio_i = 1'b1;
  end

  // {op(wr,rd), phy, reg, wdata}
  localparam logic [27:0] VEC [0:5] = '{
    {2'b01, 5'd1,  5'd2,  16'h0000},
    {2'b10, 5'd3,  5'd0,  16'hA55A},
    {2'b01, 5'd31, 5'd31, 16'h0000},
    {2'b10, 5'd0,  5'd31, 16'h8001},
    {2'b11, 5'd7,  5'd9,  16'h1234},
    {2'b01, 5'd16, 5'd1,  16'h0000}
  };

  function automatic logic [15:0] phy_resp(input logic [4:0] p, input logic [4:0] r);
    return {p, r, 6'b101101} ^ 16'h3C96;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic a, input logic [15:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic arm_model(input bit rd, input logic [4:0] p, input logic [4:0] r);
    rise_n = 0; cap = '0; oe_bad = 0; rd_mode = rd; resp = phy_resp(p, r);
  endtask

  task automatic wait_done(inout int cnt);
    while ((cmd_o[14] | cmd_o[13]) && cnt < 4000) begin
      @(negedge clk_i);
      cnt++;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 cmd", 64'(cmd_o), 64'h0);
    chk("R1 rdata", 64'(rdata_o), 64'h0);
    chk("R1 pins", 64'({mdc_o, mdio_oe_o, mdio_o}), 64'b001);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < 6; i++) begin
      logic [1:0]  op;
      logic [4:0]  p, r;
      logic [15:0] wd, cmd, prev_rd;
      bit          is_wr;
      int          cnt;
      {op, p, r, wd} = VEC[i];
      is_wr = op[1];
      cmd = {1'b0, op, p, 3'b000, r};
      prev_rd = rdata_o;
      host_wr(1'b1, wd);
      arm_model(!is_wr, p, r);
      host_wr(1'b0, cmd);
      // R2 stored command, R3 busy bit visible
      chk("R2 cmd stored", 64'(cmd_o), 64'(cmd));
      cnt = 0;
      wait_done(cnt);
      chk("R3 busy cycles", 64'(cnt), 64'(FRAME_CYC));
      chk("R3 self clear", 64'(cmd_o), 64'(cmd & 16'h9FFF));
      chk("R5 mdc rises", 64'(rise_n), 64'd64);
      if (is_wr) begin
        // R4 write frame, R10 when both bits set
        chk(op[0] ? "R10 both bits write frame" : "R4 write frame", cap,
            {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, wd});
        chk("R7 rdata kept", 64'(rdata_o), 64'(prev_rd));
      end else begin
        chk("R4 read frame head", 64'(cap[63:18]), 64'({32'hFFFF_FFFF, 2'b01, 2'b10, p, r}));
        chk("R6 oe released", 64'(oe_bad), 64'd0);
        chk("R6 read data", 64'(rdata_o), 64'(phy_resp(p, r)));
      end
      repeat (5) @(negedge clk_i);
    end

    // R8 / R11: command and write-data writes during a running write
    begin
      int cnt;
      logic [15:0] cmd;
      cmd = 16'h4506;
      host_wr(1'b1, 16'hC3C3);
      arm_model(0, 5'd5, 5'd6);
      host_wr(1'b0, cmd);
      cnt = 0;
      repeat (100) begin @(negedge clk_i); cnt++; end
      host_wr(1'b1, 16'h1111); cnt++;
      host_wr(1'b0, 16'h2903); cnt++;
      chk("R8 cmd ignored", 64'(cmd_o), 64'(cmd));
      wait_done(cnt);
      chk("R8 timing kept", 64'(cnt), 64'(FRAME_CYC));
      chk("R11 latched wdata", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd5, 5'd6, 2'b10, 16'hC3C3});
      chk("R8 no new frame", 64'(cmd_o), 64'h0506);
    end

    // R9: command with no operation bit
    begin
      arm_model(0, 5'd0, 5'd0);
      host_wr(1'b0, 16'h0105);
      chk("R9 stored", 64'(cmd_o), 64'h0105);
      repeat (60) @(negedge clk_i);
      chk("R9 no mdc", 64'(rise_n), 64'd0);
      chk("R9 no drive", 64'({mdc_o, mdio_oe_o}), 64'd0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule